// File: doc/BRIEF.md
# Injected Fault Liveness Monitor

This block decides whether a single-event upset, injected into a processor under test at a known cycle and location, can still have any effect. It is armed with the injection time, the target address, a flag that says whether the target holds data or an instruction, and the mask of upset bits. It then watches a stream of timestamped memory events (reads, writes and instruction fetches) and gives a verdict as soon as that verdict is certain.

A data target is live when the first access to its address after the injection is a read. It is dead when that first access is a write, because the write overwrites the corrupted value. It is also dead when no read ever comes. An instruction target is live only if its address is fetched after the injection. A fault campaign uses the verdict to prune effect-less faults before running full faulty simulations. The monitor holds one armed fault at a time.

Top module: `fault_liveness_monitor`

## Requirements
- R1: After reset, an `arm` pulse while `busy` is low latches the fault description. For a non-zero mask, the next cycle shows `busy`=1, `done`=0 and `live`=0.
- R2: An `arm` pulse while `busy` is high is ignored. The previously latched target stays in force.
- R3: An event whose time is at or before the injection time never affects the verdict.
- R4: For a data target, if the first qualifying event at the target address is a read (`ev_kind`=2'b00), the next cycle shows `done`=1, `live`=1 and `busy`=0.
- R5: For a data target, if the first qualifying event at the target address is a write (`ev_kind`=2'b01), the next cycle shows `done`=1, `live`=0 and `busy`=0.
- R6: For a code target, a fetch (`ev_kind`=2'b10) of the target address after the injection time gives `done`=1 and `live`=1. Reads and writes of that address are ignored.
- R7: For a data target, fetches of the target address are ignored. Events at other addresses are ignored for both target kinds.
- R8: `trace_end` while `busy` gives `done`=1 and `live`=0 on the next cycle. A deciding event in the same cycle takes precedence.
- R9: Once `done` is set, `done` and `live` hold, and later events are ignored, until the next accepted `arm`. `busy` and `done` are never high together.
- R10: An `arm` with an all-zero mask gives `done`=1, `live`=0 and `busy`=0 on the next cycle.
- R11: During and right after reset, `busy`, `done` and `live` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Load a new fault description |
| arm_time | input | TW | Injection time |
| arm_addr | input | AW | Target address |
| arm_code | input | 1 | 1 = instruction target, 0 = data target |
| arm_mask | input | DW | Upset bit mask |
| ev_valid | input | 1 | Event present this cycle |
| ev_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 none |
| ev_time | input | TW | Event timestamp |
| ev_addr | input | AW | Event address |
| trace_end | input | 1 | No further events will arrive |
| busy | output | 1 | A fault is armed and unresolved |
| done | output | 1 | A verdict is available |
| live | output | 1 | Verdict: 1 potentially active, 0 effect-less |

## Verification
The assertions check four things on every cycle: `busy` and `done` stay mutually exclusive, a verdict holds until the next arm, `live` appears only with `done`, and the end of the trace or a zero mask resolves the fault at once. They also check that an arm while busy, or a stale event, leaves the monitor pending. The scenario tests are needed for the rules that depend on event order: write-before-read, the split between fetch and data accesses, the boundary where an event time equals the injection time, and same-cycle precedence of an event over `trace_end`. A behavioural model in the bench tracks all of these every clock.

// File: rtl/fault_liveness_monitor.sv
module fault_liveness_monitor #(
  parameter int TW = 32,
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [TW-1:0] arm_time,
  input  logic [AW-1:0] arm_addr,
  input  logic          arm_code,
  input  logic [DW-1:0] arm_mask,
  input  logic          ev_valid,
  input  logic [1:0]    ev_kind,
  input  logic [TW-1:0] ev_time,
  input  logic [AW-1:0] ev_addr,
  input  logic          trace_end,
  output logic          busy,
  output logic          done,
  output logic          live
);
  localparam logic [1:0] K_READ  = 2'b00;
  localparam logic [1:0] K_WRITE = 2'b01;
  localparam logic [1:0] K_FETCH = 2'b10;

  logic [TW-1:0] inj_time;
  logic [AW-1:0] tgt_addr;
  logic          tgt_code;

  logic hit, rd_hit, wr_hit, fe_hit, decide, start;

  assign hit    = ev_valid && (ev_time > inj_time) && (ev_addr == tgt_addr);
  assign rd_hit = hit && !tgt_code && (ev_kind == K_READ);
  assign wr_hit = hit && !tgt_code && (ev_kind == K_WRITE);
  assign fe_hit = hit &&  tgt_code && (ev_kind == K_FETCH);
  assign decide = busy && (rd_hit || wr_hit || fe_hit || trace_end);
  assign start  = arm && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      live     <= 1'b0;
      inj_time <= '0;
      tgt_addr <= '0;
      tgt_code <= 1'b0;
    end else if (start) begin
      inj_time <= arm_time;
      tgt_addr <= arm_addr;
      tgt_code <= arm_code;
      busy     <= |arm_mask;
      done     <= ~|arm_mask;
      live     <= 1'b0;
    end else if (decide) begin
      busy <= 1'b0;
      done <= 1'b1;
      live <= rd_hit || fe_hit;
    end
  end
endmodule

// File: rtl/fault_liveness_monitor_chk.sv
module fault_liveness_monitor_chk #(
  parameter int TW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arm,
  input logic [DW-1:0] arm_mask,
  input logic          ev_valid,
  input logic [TW-1:0] ev_time,
  input logic [TW-1:0] inj_time,
  input logic          trace_end,
  input logic          busy,
  input logic          done,
  input logic          live
);
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(busy && done)); // R9
  AST_LIVE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) live |-> done); // R4
  AST_VERDICT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !arm |=> done && $stable(live)); // R9
  AST_END_RESOLVES: assert property (@(posedge clk) disable iff (!rst_n)
    busy && trace_end |=> done && !busy); // R8
  AST_ARM_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && arm && !ev_valid && !trace_end |=> busy); // R2
  AST_STALE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ev_valid && (ev_time <= inj_time) && !trace_end |=> busy); // R3
  AST_ZERO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    arm && !busy && (arm_mask == '0) |=> done && !live && !busy); // R10
endmodule

bind fault_liveness_monitor fault_liveness_monitor_chk #(.TW(TW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .arm_mask(arm_mask), .ev_valid(ev_valid),
  .ev_time(ev_time), .inj_time(inj_time), .trace_end(trace_end),
  .busy(busy), .done(done), .live(live)
);

// File: tb/fault_liveness_monitor_bench.sv
module fault_liveness_monitor_bench;
  logic clk = 0, rst_n = 0;
  logic arm = 0, arm_code = 0, ev_valid = 0, trace_end = 0;
  logic [31:0] arm_time = 0, ev_time = 0, arm_mask = 0;
  logic [15:0] arm_addr = 0, ev_addr = 0;
  logic [1:0]  ev_kind = 2'b11;
  logic busy, done, live;
  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  fault_liveness_monitor u_fault_liveness_monitor (
    .clk, .rst_n, .arm, .arm_time, .arm_addr, .arm_code, .arm_mask,
    .ev_valid, .ev_kind, .ev_time, .ev_addr, .trace_end, .busy, .done, .live);

  // behavioural reference
  bit m_busy, m_done, m_live, m_code;
  longint m_time;
  int m_addr;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_live = 0;
    end else if (arm && !m_busy) begin
      m_time = arm_time; m_addr = arm_addr; m_code = arm_code;
      m_busy = (arm_mask != 0); m_done = !m_busy; m_live = 0;
    end else if (m_busy) begin
      bit late_here;
      late_here = ev_valid && ev_time > m_time && ev_addr == m_addr;
      if (late_here && !m_code && ev_kind == 2'b00) begin m_busy = 0; m_done = 1; m_live = 1; end
      else if (late_here && !m_code && ev_kind == 2'b01) begin m_busy = 0; m_done = 1; m_live = 0; end
      else if (late_here && m_code && ev_kind == 2'b10) begin m_busy = 0; m_done = 1; m_live = 1; end
      else if (trace_end) begin m_busy = 0; m_done = 1; m_live = 0; end
    end
  end

  always @(negedge clk) begin
    cycles++;
    checks++;
    if ({busy, done, live} !== {m_busy, m_done, m_live}) begin
      errors++;
      $display("FAIL model R9 cycle %0d: got %b%b%b expected %b%b%b", cycles,
               busy, done, live, m_busy, m_done, m_live);
    end
    if (cycles > 100000 && !finished) begin
      errors++;
      $display("FAIL watchdog R11: got timeout expected completion");
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input bit b, input bit d, input bit l);
    checks++;
    if ({busy, done, live} !== {b, d, l}) begin
      errors++;
      $display("FAIL %s: got busy/done/live %b%b%b expected %b%b%b", tag, busy, done, live, b, d, l);
    end
  endtask

  task automatic do_arm(input int t, input int a, input bit c, input int m);
    arm = 1; arm_time = t; arm_addr = a[15:0]; arm_code = c; arm_mask = m;
    @(negedge clk); arm = 0;
  endtask

  task automatic do_ev(input logic [1:0] k, input int t, input int a, input bit e);
    ev_valid = 1; ev_kind = k; ev_time = t; ev_addr = a[15:0]; trace_end = e;
    @(negedge clk); ev_valid = 0; ev_kind = 2'b11; trace_end = 0;
  endtask

  task automatic do_end();
    trace_end = 1; @(negedge clk); trace_end = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset", 0, 0, 0);
    rst_n = 1; @(negedge clk);
    check("R11 after reset", 0, 0, 0);

    do_arm(100, 'h10, 0, 1);          check("R1 arm", 1, 0, 0);
    do_ev(2'b01, 90, 'h10, 0);        check("R3 early write", 1, 0, 0);
    do_ev(2'b00, 150, 'h11, 0);       check("R7 other addr", 1, 0, 0);
    do_ev(2'b10, 160, 'h10, 0);       check("R7 fetch data", 1, 0, 0);
    do_ev(2'b00, 170, 'h10, 0);       check("R4 read live", 0, 1, 1);
    repeat (3) @(negedge clk);        check("R9 hold", 0, 1, 1);

    do_arm(200, 'h10, 0, 'h80);       check("R1 rearm", 1, 0, 0);
    do_ev(2'b01, 250, 'h10, 0);       check("R5 write dead", 0, 1, 0);
    do_ev(2'b00, 260, 'h10, 0);       check("R9 later read ignored", 0, 1, 0);

    do_arm(300, 'h40, 1, 4);
    do_ev(2'b00, 310, 'h40, 0);       check("R6 read code ignored", 1, 0, 0);
    do_ev(2'b01, 311, 'h40, 0);       check("R6 write code ignored", 1, 0, 0);
    do_ev(2'b10, 300, 'h40, 0);       check("R3 equal time", 1, 0, 0);
    do_ev(2'b10, 301, 'h40, 0);       check("R6 fetch live", 0, 1, 1);

    do_arm(400, 'h20, 0, 1);
    do_arm(400, 'h30, 0, 1);          check("R2 arm busy", 1, 0, 0);
    do_ev(2'b00, 500, 'h30, 0);       check("R2 second target ignored", 1, 0, 0);
    do_ev(2'b00, 501, 'h20, 0);       check("R2 first target kept", 0, 1, 1);

    do_arm(600, 'h50, 0, 2);
    do_end();                         check("R8 end dead", 0, 1, 0);
    do_arm(700, 'h60, 0, 2);
    do_ev(2'b00, 701, 'h60, 1);       check("R8 event precedence", 0, 1, 1);

    do_arm(800, 'h70, 0, 0);          check("R10 zero mask", 0, 1, 0);
    do_arm(900, 'h70, 1, 1);          check("R1 arm after zero mask", 1, 0, 0);
    do_end();                         check("R8 end code", 0, 1, 0);

    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule